// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of the lines in one private cache that sits on a shared snooping bus. It holds one of four states for each of a small, parameterised set of lines. Each line also holds an address tag, so that a bus snoop only acts on the copy it really names. Processor reads and writes are checked against the line state. A miss, or a write that needs ownership, is turned into a bus transaction. Snooped reads and read-for-ownership requests from other caches downgrade or invalidate the local copy. They also drive the wired-OR shared line and the data strobes that the bus needs.

A processor request is presented on `cpu_req`, together with `cpu_wr` and `cpu_addr`. It is held until `cpu_done` pulses. A hit completes in the cycle in which it is presented. A miss first raises `bus_req` in the following cycle and holds it until the environment pulses `bus_done`. In that same cycle the environment also presents the sampled wired-OR value on `bus_shared_in`. A snoop is a single-cycle event on `snoop_valid`. Its responses are combinational in that same cycle, and the line state changes at the next clock edge.

The line index is taken from the low address bits and the tag from the rest. A miss that lands on an index already holding another tag overwrites that line, and eviction is handled outside the block. Bus arbitration, data storage, replacement and memory lie outside it as well.

Top module: `mesi_line_ctrl`

States: Invalid (`I`, code 00), Shared (`S`, 01), Exclusive (`E`, 10) and Modified (`M`, 11). Transitions:
- read-fill-clean: `I` to `E`
- read-fill-shared: `I` to `S`
- silent-own: `E` to `M`
- upgrade: `S` to `M` over BusRdX
- write-fill: `I` to `M`
- flush-down: `M` to `S` on a snooped BusRd
- supply-down: `E` to `S` on a snooped BusRd
- kill: any valid state to `I` on a snooped BusRdX

The request sequencer has two states, idle and wait-bus.

## Requirements
- R1: After reset every line is Invalid. `bus_req`, `cpu_done`, `snoop_shared_out`, `snoop_flush` and `snoop_supply` are low, and even a snoop gets no response.
- R2: A read miss raises `bus_req` with `bus_op`=01 (BusRd) one cycle after the request. In the cycle in which `bus_done` is high, `cpu_done` is high and `cpu_state` is E (10) if `bus_shared_in` was low, or S (01) if it was high.
- R3: `snoop_shared_out` is high in the cycle of a snooped BusRd (`snoop_op`=0) only when the indexed line is valid and its tag matches. A tag mismatch gives no response.
- R4: A write that hits in E completes in the same cycle with `cpu_state`=M and no bus request. A write that hits in M stays M, also without a bus request.
- R5: A write to an Invalid or mismatched line, or to a Shared line, raises `bus_req` with `bus_op`=10 (BusRdX) and ends in M. `bus_nodata` is high only while the line is Shared with a matching tag.
- R6: A snooped BusRd to an M line gives `snoop_flush` and leaves the line S. To an E line it gives `snoop_supply` and leaves the line S. To an S line it gives neither, and the line stays S.
- R7: A snooped BusRdX (`snoop_op`=1) moves any valid matching line to I. `snoop_flush` is high only if the line was M, and `snoop_shared_out` stays low.
- R8: A read hit in M, E or S completes in the cycle it is presented, with no bus request, and reports the current state.
- R9: When a snoop and a processor request address the same line in the same cycle, the snoop is applied first. The processor request is then judged against the resulting state.
- R10: While `bus_req` is high and `bus_done` low, `bus_req`, `bus_op` and `bus_addr` hold. `bus_nodata` follows snoops that change the pending line's state.
- R11: A miss overwrites the tag of the indexed line. The displaced address then no longer answers snoops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_state | output | 2 | Line state after the completing request |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 01 BusRd, 10 BusRdX, 00 none |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_nodata | output | 1 | BusRdX is an upgrade and needs no data |
| bus_done | input | 1 | Own bus transaction finishes this cycle |
| bus_shared_in | input | 1 | Sampled wired-OR shared line, valid with `bus_done` |
| snoop_valid | input | 1 | Snooped request from another cache |
| snoop_op | input | 1 | 0 BusRd, 1 BusRdX |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared_out | output | 1 | Drive to the wired-OR shared line |
| snoop_flush | output | 1 | Dirty data is written out to the bus |
| snoop_supply | output | 1 | Clean data is supplied cache-to-cache |

## Verification
The bench builds the block with its defaults: four lines and 8-bit addresses, which gives two index bits and six tag bits. With only four lines, two addresses that share an index but differ in tag are easy to pick. That brings tag-mismatch snoops and miss replacement within reach, alongside every state transition. The small width also lets a snoop and a processor request collide on one line, and lets a snoop strike the pending line while the block waits on the bus.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_t;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_RD   = 2'b01,
        BOP_RDX  = 2'b10
    } bus_op_t;

    typedef enum logic {
        REQ_IDLE,
        REQ_WAIT
    } req_state_t;
endpackage

// File: rtl/mesi_line_array.sv
`timescale 1ns/1ps
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snp_we,
    input  logic [IDX_W-1:0]      snp_idx,
    input  line_state_t           snp_st,
    input  logic                  fill_we,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [TAG_W-1:0]      fill_tag,
    input  line_state_t           fill_st,
    output line_state_t           line_st  [NUM_LINES],
    output logic [TAG_W-1:0]      line_tag [NUM_LINES]
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_t      st_q;
        logic [TAG_W-1:0] tag_q;

        // processor-side write wins: it was evaluated on the post-snoop state
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= ST_I;
                tag_q <= '0;
            end else if (fill_we && fill_idx == IDX_W'(g)) begin
                st_q  <= fill_st;
                tag_q <= fill_tag;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                st_q  <= snp_st;
            end
        end

        assign line_st[g]  = st_q;
        assign line_tag[g] = tag_q;
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 6
) (
    input  logic                 snoop_valid,
    input  logic                 snoop_op,
    input  logic [ADDR_W-1:0]    snoop_addr,
    input  line_state_t          line_st  [NUM_LINES],
    input  logic [TAG_W-1:0]     line_tag [NUM_LINES],
    output logic                 shared_out,
    output logic                 flush,
    output logic                 supply,
    output logic                 upd_we,
    output logic [IDX_W-1:0]     upd_idx,
    output line_state_t          upd_st
);
    line_state_t cur;
    logic        match;

    always_comb begin
        upd_idx    = snoop_addr[IDX_W-1:0];
        cur        = line_st[upd_idx];
        match      = snoop_valid && (line_tag[upd_idx] == snoop_addr[ADDR_W-1:IDX_W])
                     && (cur != ST_I);
        shared_out = 1'b0;
        flush      = 1'b0;
        supply     = 1'b0;
        upd_we     = match;
        upd_st     = cur;
        if (match) begin
            unique case (cur)
                ST_M: begin
                    flush      = 1'b1;
                    shared_out = !snoop_op;
                    upd_st     = snoop_op ? ST_I : ST_S;
                end
                ST_E: begin
                    supply     = !snoop_op;
                    shared_out = !snoop_op;
                    upd_st     = snoop_op ? ST_I : ST_S;
                end
                ST_S: begin
                    shared_out = !snoop_op;
                    upd_st     = snoop_op ? ST_I : ST_S;
                end
                ST_I: upd_st = ST_I;
            endcase
        end
    end
endmodule

// File: rtl/mesi_req_fsm.sv
`timescale 1ns/1ps
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  line_state_t       acc_st,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              cpu_done,
    output line_state_t       cpu_state,
    output logic              bus_req,
    output bus_op_t           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_nodata,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output line_state_t       fill_st
);
    req_state_t        fsm_q, fsm_d;
    logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
    logic              pend_wr_q, pend_wr_d;
    logic [ADDR_W-1:0] acc_addr;
    logic              tag_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= REQ_IDLE;
            pend_addr_q <= '0;
            pend_wr_q   <= 1'b0;
        end else begin
            fsm_q       <= fsm_d;
            pend_addr_q <= pend_addr_d;
            pend_wr_q   <= pend_wr_d;
        end
    end

    always_comb begin
        acc_addr    = (fsm_q == REQ_WAIT) ? pend_addr_q : cpu_addr;
        acc_idx     = acc_addr[IDX_W-1:0];
        tag_hit     = (acc_tag == acc_addr[ADDR_W-1:IDX_W]) && (acc_st != ST_I);
        fsm_d       = fsm_q;
        pend_addr_d = pend_addr_q;
        pend_wr_d   = pend_wr_q;
        cpu_done    = 1'b0;
        cpu_state   = ST_I;
        bus_req     = 1'b0;
        bus_op      = BOP_NONE;
        bus_addr    = '0;
        bus_nodata  = 1'b0;
        fill_we     = 1'b0;
        fill_idx    = acc_addr[IDX_W-1:0];
        fill_tag    = acc_addr[ADDR_W-1:IDX_W];
        fill_st     = ST_I;
        unique case (fsm_q)
            REQ_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_wr && tag_hit) begin
                        cpu_done  = 1'b1;
                        cpu_state = acc_st;
                    end else if (cpu_wr && tag_hit && (acc_st == ST_E || acc_st == ST_M)) begin
                        cpu_done  = 1'b1;
                        cpu_state = ST_M;
                        fill_we   = 1'b1;
                        fill_st   = ST_M;
                    end else begin
                        fsm_d       = REQ_WAIT;
                        pend_addr_d = cpu_addr;
                        pend_wr_d   = cpu_wr;
                    end
                end
            end
            REQ_WAIT: begin
                bus_req    = 1'b1;
                bus_op     = pend_wr_q ? BOP_RDX : BOP_RD;
                bus_addr   = pend_addr_q;
                bus_nodata = pend_wr_q && tag_hit && (acc_st == ST_S);
                if (bus_done) begin
                    fill_we   = 1'b1;
                    fill_st   = pend_wr_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
                    cpu_done  = 1'b1;
                    cpu_state = fill_st;
                    fsm_d     = REQ_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic [1:0]        cpu_state,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_nodata,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    input  logic              snoop_valid,
    input  logic              snoop_op,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_shared_out,
    output logic              snoop_flush,
    output logic              snoop_supply
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_state_t      line_st  [NUM_LINES];
    logic [TAG_W-1:0] line_tag [NUM_LINES];

    logic             snp_we;
    logic [IDX_W-1:0] snp_idx;
    line_state_t      snp_st;

    logic [IDX_W-1:0] acc_idx;
    line_state_t      acc_st;
    logic [TAG_W-1:0] acc_tag;
    logic             fill_we;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;
    line_state_t      fill_st;
    line_state_t      done_st;
    bus_op_t          op_enc;

    mesi_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .snp_we   (snp_we),
        .snp_idx  (snp_idx),
        .snp_st   (snp_st),
        .fill_we  (fill_we),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .fill_st  (fill_st),
        .line_st  (line_st),
        .line_tag (line_tag)
    );

    mesi_snoop_unit #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_op    (snoop_op),
        .snoop_addr  (snoop_addr),
        .line_st     (line_st),
        .line_tag    (line_tag),
        .shared_out  (snoop_shared_out),
        .flush       (snoop_flush),
        .supply      (snoop_supply),
        .upd_we      (snp_we),
        .upd_idx     (snp_idx),
        .upd_st      (snp_st)
    );

    // processor side sees the line as the same-cycle snoop leaves it
    always_comb begin
        acc_st  = (snp_we && snp_idx == acc_idx) ? snp_st : line_st[acc_idx];
        acc_tag = line_tag[acc_idx];
    end

    mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_wr        (cpu_wr),
        .cpu_addr      (cpu_addr),
        .acc_st        (acc_st),
        .acc_tag       (acc_tag),
        .bus_done      (bus_done),
        .bus_shared_in (bus_shared_in),
        .acc_idx       (acc_idx),
        .cpu_done      (cpu_done),
        .cpu_state     (done_st),
        .bus_req       (bus_req),
        .bus_op        (op_enc),
        .bus_addr      (bus_addr),
        .bus_nodata    (bus_nodata),
        .fill_we       (fill_we),
        .fill_idx      (fill_idx),
        .fill_tag      (fill_tag),
        .fill_st       (fill_st)
    );

    assign cpu_state = done_st;
    assign bus_op    = op_enc;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctrl_chk
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_done,
    input logic [1:0]        cpu_state,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_done,
    input logic              bus_shared_in,
    input logic              snoop_valid,
    input logic              snoop_op,
    input logic              snoop_shared_out,
    input logic              snoop_flush,
    input logic              snoop_supply
);
    assert_fill_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == BOP_RD && bus_done) |->
        (cpu_done && cpu_state == (bus_shared_in ? ST_S : ST_E)));

    assert_shared_only_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_shared_out |-> (snoop_valid && !snoop_op));

    assert_write_ends_modified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_wr) |-> (cpu_state == ST_M));

    assert_one_data_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_flush && snoop_supply));

    assert_no_supply_on_rdx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply |-> (snoop_valid && !snoop_op));

    assert_request_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_op)));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cpu_wr           (cpu_wr),
    .cpu_done         (cpu_done),
    .cpu_state        (cpu_state),
    .bus_req          (bus_req),
    .bus_op           (bus_op),
    .bus_addr         (bus_addr),
    .bus_done         (bus_done),
    .bus_shared_in    (bus_shared_in),
    .snoop_valid      (snoop_valid),
    .snoop_op         (snoop_op),
    .snoop_shared_out (snoop_shared_out),
    .snoop_flush      (snoop_flush),
    .snoop_supply     (snoop_supply)
);

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_done;
    logic [1:0]    cpu_state;
    logic          bus_req;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          bus_nodata;
    logic          bus_done = 1'b0, bus_shared_in = 1'b0;
    logic          snoop_valid = 1'b0, snoop_op = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          snoop_shared_out, snoop_flush, snoop_supply;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done), .cpu_state(cpu_state), .bus_req(bus_req), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_nodata(bus_nodata), .bus_done(bus_done),
        .bus_shared_in(bus_shared_in), .snoop_valid(snoop_valid), .snoop_op(snoop_op),
        .snoop_addr(snoop_addr), .snoop_shared_out(snoop_shared_out),
        .snoop_flush(snoop_flush), .snoop_supply(snoop_supply)
    );

    // snp, op, addr, shin, exp bus op, exp nodata, exp state, exp {shared,flush,supply}, req
    typedef struct packed {
        logic       snp;
        logic       op;
        logic [7:0] addr;
        logic       shin;
        logic [1:0] ebus;
        logic       end_nd;
        logic [1:0] est;
        logic [2:0] esnp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,8'h10,1'b0,2'd1,1'b0,2'd2,3'b000,4'd2},  // R2 read miss, clean -> E
        '{1'b0,1'b0,8'h10,1'b0,2'd0,1'b0,2'd2,3'b000,4'd8},  // R8 read hit E
        '{1'b0,1'b1,8'h10,1'b0,2'd0,1'b0,2'd3,3'b000,4'd4},  // R4 silent E->M
        '{1'b1,1'b0,8'h10,1'b0,2'd0,1'b0,2'd0,3'b110,4'd6},  // R6 BusRd on M: flush
        '{1'b0,1'b0,8'h10,1'b0,2'd0,1'b0,2'd1,3'b000,4'd6},  // R6 line now S
        '{1'b0,1'b1,8'h10,1'b0,2'd2,1'b1,2'd3,3'b000,4'd5},  // R5 upgrade S->M
        '{1'b1,1'b1,8'h10,1'b0,2'd0,1'b0,2'd0,3'b010,4'd7},  // R7 BusRdX on M
        '{1'b0,1'b0,8'h10,1'b1,2'd1,1'b0,2'd1,3'b000,4'd2},  // R2 read miss, shared -> S
        '{1'b1,1'b1,8'h10,1'b0,2'd0,1'b0,2'd0,3'b000,4'd7},  // R7 BusRdX on S
        '{1'b0,1'b1,8'h21,1'b0,2'd2,1'b0,2'd3,3'b000,4'd5},  // R5 write miss
        '{1'b0,1'b0,8'h22,1'b0,2'd1,1'b0,2'd2,3'b000,4'd2},  // R2
        '{1'b1,1'b0,8'h22,1'b0,2'd0,1'b0,2'd0,3'b101,4'd6},  // R6 BusRd on E: supply
        '{1'b1,1'b0,8'h26,1'b0,2'd0,1'b0,2'd0,3'b000,4'd3},  // R3 tag mismatch
        '{1'b0,1'b0,8'h22,1'b0,2'd0,1'b0,2'd1,3'b000,4'd8},  // R8 read hit S
        '{1'b0,1'b0,8'h25,1'b0,2'd1,1'b0,2'd2,3'b000,4'd11}, // R11 replaces 0x21
        '{1'b1,1'b0,8'h21,1'b0,2'd0,1'b0,2'd0,3'b000,4'd11}, // R11 old tag silent
        '{1'b1,1'b0,8'h25,1'b0,2'd0,1'b0,2'd0,3'b101,4'd3},  // R3 matching tag
        '{1'b0,1'b1,8'h25,1'b0,2'd2,1'b1,2'd3,3'b000,4'd5},  // R5 upgrade
        '{1'b0,1'b1,8'h25,1'b0,2'd0,1'b0,2'd3,3'b000,4'd4}   // R4 M stays M
    };

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_cpu(input logic wr, input logic [7:0] a, input logic shin,
                          input int ebus, input int end_nd, input int est, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
        #1;
        if (cpu_done) begin
            chk(tag, 0, ebus, "bus op (hit path)");
            chk(tag, cpu_state, est, "state");
        end else begin
            @(negedge clk); #1;
            chk(tag, bus_req, 1, "bus_req");
            chk(tag, bus_op, ebus, "bus_op");
            chk(tag, bus_nodata, end_nd, "nodata");
            bus_done = 1'b1; bus_shared_in = shin;
            #1;
            chk(tag, cpu_done, 1, "done");
            chk(tag, cpu_state, est, "state");
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_done = 1'b0; bus_shared_in = 1'b0;
    endtask

    task automatic do_snp(input logic op, input logic [7:0] a, input int esnp, input string tag);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_op = op; snoop_addr = a;
        #1;
        chk(tag, {snoop_shared_out, snoop_flush, snoop_supply}, esnp, "snoop {shared,flush,supply}");
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        snoop_valid = 1'b1; snoop_op = 1'b0; snoop_addr = 8'h00;
        #1;
        chk("R1", bus_req, 0, "bus_req after reset");
        chk("R1", cpu_done, 0, "cpu_done after reset");
        chk("R1", {snoop_shared_out, snoop_flush, snoop_supply}, 0, "snoop response after reset");
        @(negedge clk);
        snoop_valid = 1'b0;
        do_cpu(1'b0, 8'h00, 1'b1, 1, 0, 1, "R1");

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d", VEC[i].req);
            if (VEC[i].snp) do_snp(VEC[i].op, VEC[i].addr, int'(VEC[i].esnp), t);
            else do_cpu(VEC[i].op, VEC[i].addr, VEC[i].shin, int'(VEC[i].ebus),
                        int'(VEC[i].end_nd), int'(VEC[i].est), t);
        end

        // R9: BusRdX snoop and write on an E line in the same cycle
        do_cpu(1'b0, 8'h03, 1'b0, 1, 0, 2, "R9");
        @(negedge clk);
        snoop_valid = 1'b1; snoop_op = 1'b1; snoop_addr = 8'h03;
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h03;
        #1;
        chk("R9", cpu_done, 0, "write not silent after snooped kill");
        chk("R9", snoop_flush, 0, "no flush from E");
        @(negedge clk);
        snoop_valid = 1'b0;
        #1;
        chk("R9", bus_op, 2, "BusRdX after kill");
        chk("R9", bus_nodata, 0, "data needed after kill");
        bus_done = 1'b1;
        #1;
        chk("R9", cpu_state, 3, "ends M");
        @(negedge clk);
        cpu_req = 1'b0; bus_done = 1'b0;

        // R9: BusRd snoop and read on an M line in the same cycle
        @(negedge clk);
        snoop_valid = 1'b1; snoop_op = 1'b0; snoop_addr = 8'h03;
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 8'h03;
        #1;
        chk("R9", snoop_flush, 1, "flush from M");
        chk("R9", cpu_done, 1, "read hit");
        chk("R9", cpu_state, 1, "read sees S");
        @(negedge clk);
        snoop_valid = 1'b0; cpu_req = 1'b0;

        // R10: snoop kills the pending upgrade line while waiting on the bus
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h03;
        @(negedge clk); #1;
        chk("R10", bus_nodata, 1, "upgrade from S");
        snoop_valid = 1'b1; snoop_op = 1'b1; snoop_addr = 8'h03;
        #1;
        chk("R10", bus_nodata, 0, "nodata drops on snooped kill");
        @(negedge clk);
        snoop_valid = 1'b0;
        #1;
        chk("R10", bus_req, 1, "request held");
        chk("R10", bus_addr, 8'h03, "address held");
        chk("R10", bus_nodata, 0, "line stays invalid");
        bus_done = 1'b1;
        #1;
        chk("R10", cpu_state, 3, "ends M");
        @(negedge clk);
        cpu_req = 1'b0; bus_done = 1'b0;

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule